// File: doc/BRIEF.md
# Aperture Delay Code Ramp Controller

This block produces the control word for a sampling-clock delay line. The word carries a clock-invert flag, a coarse delay code and a fine delay code. Software sets the manual value through a small byte-wide register write port. A calibration engine can supply a measured value instead, and a select bit chooses the source. While calibration is selected, the output changes only when the engine flags its result as valid. Until then the output holds its last value.

Coarse-code changes can upset a running clock when they jump. The block can therefore slew the coarse code toward a newly written target. It moves a fixed number of codes once per timer window, in either direction. A free-running counter sets the window length, which is 2^TIMER_W cycles (256 by default). The fine code and the invert flag always follow their registers directly. With slewing off, a new coarse target reaches the output on the next clock.

Top module: `aperture_delay_ramp`

## Requirements
- R1: The output word is {invert, coarse, fine}. With the default widths, bit 16 is the invert flag, bits 15:8 are the coarse code and bits 7:0 are the fine code. Write addresses are: 0 for source select (bit 0, where 1 selects calibration), 1 for the fine code, 2 for the coarse target, 3 for invert (bit 0), and 4 for slew configuration (bit 0 enables slewing, bit 1 selects the fast rate).
- R2: While reset is active, all registers and the output word are zero and slewing is disabled. Reset is released synchronously, two clock edges after rst_n rises.
- R3: When calibration is selected and cal_done is 1 at a clock edge, the output takes cal_word at that edge. The manual registers have no effect on the output.
- R4: When calibration is selected and cal_done is 0, the output word holds its previous value.
- R5: With slewing disabled and manual source selected, the coarse output equals the coarse target register one clock after the write edge. This is well within 1024 cycles.
- R6: The fine code and the invert flag follow their registers one clock after the write edge, also while a coarse slew is in progress. They are never slewed.
- R7: With slewing enabled and the slow rate selected, the coarse output moves one code toward the target once per timer window.
- R8: With slewing enabled and the fast rate selected, the coarse output moves four codes toward the target once per window, up or down. When fewer than four codes remain, the step lands exactly on the target.
- R9: Once the coarse output equals the target, it stays there until the target changes.
- R10: A target written during a slew redirects the slew from the current coarse output. The output does not restart or jump.
- R11: The window timer is a free-running counter. A slew step happens only at the cycle where it wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| cal_word | input | 17 | Calibration result word |
| cal_done | input | 1 | Calibration result valid |
| dly_word | output | 17 | Registered delay control word |

## Verification
The bench builds the block with the default 8-bit coarse and fine codes. It shrinks TIMER_W to 4, which gives a 16-cycle window. With the shorter window, slews across the whole coarse range run at both rates, up and down. Redirections in mid-slew, partial final fast steps and calibration hand-overs all fit in a few thousand cycles. The full range is still covered, so the ends of the code range are exercised.

// File: rtl/adr_pkg.sv
package adr_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_SRC    = 3'd0,
    A_FINE   = 3'd1,
    A_COARSE = 3'd2,
    A_INV    = 3'd3,
    A_SLEW   = 3'd4
  } adr_addr_e;
endpackage

// File: rtl/adr_ctrl_regs.sv
module adr_ctrl_regs
  import adr_pkg::*;
#(
  parameter int COARSE_W = 8,
  parameter int FINE_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                cal_sel,
  output logic                inv_r,
  output logic [FINE_W-1:0]   fine_r,
  output logic [COARSE_W-1:0] tgt_r,
  output logic                slew_en,
  output logic                slew_fast
);
  logic                cal_sel_d, inv_d, slew_en_d, slew_fast_d;
  logic [FINE_W-1:0]   fine_d;
  logic [COARSE_W-1:0] tgt_d;

  always_comb begin
    cal_sel_d   = cal_sel;
    inv_d       = inv_r;
    fine_d      = fine_r;
    tgt_d       = tgt_r;
    slew_en_d   = slew_en;
    slew_fast_d = slew_fast;
    if (wr_en) begin
      unique case (wr_addr)
        A_SRC:    cal_sel_d = wr_data[0];
        A_FINE:   fine_d    = wr_data[FINE_W-1:0];
        A_COARSE: tgt_d     = wr_data[COARSE_W-1:0];
        A_INV:    inv_d     = wr_data[0];
        A_SLEW: begin
          slew_en_d   = wr_data[0];
          slew_fast_d = wr_data[1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_sel   <= 1'b0;
      inv_r     <= 1'b0;
      fine_r    <= '0;
      tgt_r     <= '0;
      slew_en   <= 1'b0;
      slew_fast <= 1'b0;
    end else if (wr_en) begin
      cal_sel   <= cal_sel_d;
      inv_r     <= inv_d;
      fine_r    <= fine_d;
      tgt_r     <= tgt_d;
      slew_en   <= slew_en_d;
      slew_fast <= slew_fast_d;
    end
  end

  // R2: configuration is clear straight after reset release
  a_r2_cfg_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!slew_en && !cal_sel));
endmodule

// File: rtl/adr_step_timer.sv
module adr_step_timer #(
  parameter int TIMER_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [TIMER_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    tick  = &cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R11: the window counter wraps to zero after the tick
  a_r11_timer_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));
endmodule

// File: rtl/adr_coarse_slew.sv
module adr_coarse_slew #(
  parameter int COARSE_W  = 8,
  parameter int FAST_STEP = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                load,
  input  logic                hold,
  input  logic [COARSE_W-1:0] load_val,
  input  logic                slew_en,
  input  logic                slew_fast,
  input  logic [COARSE_W-1:0] target,
  output logic [COARSE_W-1:0] coarse_q
);
  localparam logic [COARSE_W-1:0] STEP_FAST = COARSE_W'(FAST_STEP);
  localparam logic [COARSE_W-1:0] STEP_SLOW = COARSE_W'(1);

  logic [COARSE_W-1:0] coarse_d, step, gap_up, gap_dn;
  logic                manual;

  always_comb begin
    manual   = !load && !hold;
    step     = slew_fast ? STEP_FAST : STEP_SLOW;
    gap_up   = target - coarse_q;
    gap_dn   = coarse_q - target;
    coarse_d = coarse_q;
    if (load) begin
      coarse_d = load_val;
    end else if (hold) begin
      coarse_d = coarse_q;
    end else if (!slew_en) begin
      coarse_d = target;
    end else if (tick && (coarse_q != target)) begin
      if (coarse_q < target)
        coarse_d = (gap_up <= step) ? target : coarse_q + step;
      else
        coarse_d = (gap_dn <= step) ? target : coarse_q - step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) coarse_q <= '0;
    else        coarse_q <= coarse_d;
  end

  // R5: without slewing the target is applied on the next edge
  a_r5_direct_apply: assert property (@(posedge clk) disable iff (!rst_n)
    (manual && !slew_en) |=> (coarse_q == $past(target)));
  // R9: at the target the code rests
  a_r9_rest_at_target: assert property (@(posedge clk) disable iff (!rst_n)
    (manual && slew_en && (coarse_q == target)) |=> $stable(coarse_q));
  // R11: no movement between window wraps
  a_r11_step_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (manual && slew_en && !tick) |=> $stable(coarse_q));
  // R8: a step never passes the target, from below or above
  a_r8_no_overshoot_up: assert property (@(posedge clk) disable iff (!rst_n)
    (manual && slew_en && (coarse_q <= target)) |=> (coarse_q <= $past(target)));
  a_r8_no_overshoot_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (manual && slew_en && (coarse_q >= target)) |=> (coarse_q >= $past(target)));
endmodule

// File: rtl/aperture_delay_ramp.sv
module aperture_delay_ramp
  import adr_pkg::*;
#(
  parameter int COARSE_W  = 8,
  parameter int FINE_W    = 8,
  parameter int TIMER_W   = 8,
  parameter int FAST_STEP = 4,
  localparam int WORD_W   = 1 + COARSE_W + FINE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [WORD_W-1:0]   cal_word,
  input  logic                cal_done,
  output logic [WORD_W-1:0]   dly_word
);
  logic                rst_s1, rst_s;
  logic                cal_sel, inv_r, slew_en, slew_fast, tick;
  logic [FINE_W-1:0]   fine_r, fine_q, fine_d;
  logic [COARSE_W-1:0] tgt_r, coarse_q;
  logic                inv_q, inv_d, load, hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s  <= rst_s1;
    end
  end

  adr_ctrl_regs #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_regs (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cal_sel(cal_sel), .inv_r(inv_r), .fine_r(fine_r),
    .tgt_r(tgt_r), .slew_en(slew_en), .slew_fast(slew_fast)
  );

  adr_step_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk(clk), .rst_n(rst_s), .tick(tick)
  );

  assign load = cal_sel && cal_done;
  assign hold = cal_sel && !cal_done;

  adr_coarse_slew #(.COARSE_W(COARSE_W), .FAST_STEP(FAST_STEP)) u_slew (
    .clk(clk), .rst_n(rst_s), .tick(tick), .load(load), .hold(hold),
    .load_val(cal_word[FINE_W +: COARSE_W]), .slew_en(slew_en),
    .slew_fast(slew_fast), .target(tgt_r), .coarse_q(coarse_q)
  );

  always_comb begin
    inv_d  = inv_q;
    fine_d = fine_q;
    if (load) begin
      inv_d  = cal_word[WORD_W-1];
      fine_d = cal_word[FINE_W-1:0];
    end else if (!hold) begin
      inv_d  = inv_r;
      fine_d = fine_r;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      inv_q  <= 1'b0;
      fine_q <= '0;
    end else begin
      inv_q  <= inv_d;
      fine_q <= fine_d;
    end
  end

  assign dly_word = {inv_q, coarse_q, fine_q};

  // R3: a valid calibration result is taken whole
  a_r3_cal_taken: assert property (@(posedge clk) disable iff (!rst_s)
    load |=> (dly_word == $past(cal_word)));
  // R4: pending calibration freezes the word
  a_r4_hold_pending: assert property (@(posedge clk) disable iff (!rst_s)
    hold |=> $stable(dly_word));
  // R6: fine and invert track their registers in manual mode
  a_r6_fine_direct: assert property (@(posedge clk) disable iff (!rst_s)
    !cal_sel |=> (dly_word[FINE_W-1:0] == $past(fine_r) &&
                  dly_word[WORD_W-1] == $past(inv_r)));
endmodule

// File: tb/sim_aperture_delay_ramp.sv
module sim_aperture_delay_ramp;
  localparam int CW = 8;
  localparam int FW = 8;
  localparam int TW = 4;
  localparam int WIN = 1 << TW;
  localparam int WW = 1 + CW + FW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [WW-1:0] cal_word = '0;
  logic          cal_done = 1'b0;
  logic [WW-1:0] dly_word;

  int    n_run = 0, n_fail = 0;
  bit    cmp_on = 0, finished = 0;
  string phase = "R2";

  always #4 clk = ~clk;

  aperture_delay_ramp #(.COARSE_W(CW), .FINE_W(FW), .TIMER_W(TW), .FAST_STEP(4)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cal_word(cal_word), .cal_done(cal_done),
    .dly_word(dly_word)
  );

  // behavioural reference
  int m_inv, m_co, m_fi, m_cnt, m_rel;
  int r_sel, r_inv, r_fine, r_tgt, r_en, r_fast;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_inv = 0; m_co = 0; m_fi = 0; m_cnt = 0; m_rel = 0;
      r_sel = 0; r_inv = 0; r_fine = 0; r_tgt = 0; r_en = 0; r_fast = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      if (r_sel != 0) begin
        if (cal_done) begin
          m_inv = int'(cal_word[WW-1]);
          m_co  = int'(cal_word[FW +: CW]);
          m_fi  = int'(cal_word[FW-1:0]);
        end
      end else begin
        m_inv = r_inv;
        m_fi  = r_fine;
        if (r_en == 0) m_co = r_tgt;
        else if (m_cnt == WIN - 1 && m_co != r_tgt) begin
          int st;
          st = (r_fast != 0) ? 4 : 1;
          if (m_co < r_tgt) m_co = (r_tgt - m_co <= st) ? r_tgt : m_co + st;
          else              m_co = (m_co - r_tgt <= st) ? r_tgt : m_co - st;
        end
      end
      m_cnt = (m_cnt + 1) % WIN;
      if (wr_en) begin
        case (wr_addr)
          3'd0: r_sel  = int'(wr_data[0]);
          3'd1: r_fine = int'(wr_data);
          3'd2: r_tgt  = int'(wr_data);
          3'd3: r_inv  = int'(wr_data[0]);
          3'd4: begin r_en = int'(wr_data[0]); r_fast = int'(wr_data[1]); end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [WW-1:0] got, input logic [WW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %05h expected %05h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) chk(phase, dly_word, {m_inv[0], m_co[CW-1:0], m_fi[FW-1:0]});
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [WW-1:0] snap;
    idle(3);
    chk("R2 in reset", dly_word, '0);
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    chk("R2 after release", dly_word, '0);
    cmp_on = 1;

    phase = "R1_R5";
    wr(3'd1, 8'h5A); wr(3'd3, 8'h01); wr(3'd2, 8'h30);
    idle(1);
    chk("R1 R5 direct word", dly_word, 17'h1305A);

    phase = "R7";
    wr(3'd4, 8'h01); wr(3'd2, 8'h34);
    idle(4 * WIN + 4);
    chk("R7 slow up reached", dly_word, 17'h1345A);
    phase = "R9";
    idle(3 * WIN);
    chk("R9 rests at target", dly_word, 17'h1345A);

    phase = "R8";
    wr(3'd4, 8'h03); wr(3'd2, 8'h3E);
    idle(3 * WIN + 4);
    chk("R8 fast up partial step", dly_word, 17'h13E5A);
    wr(3'd2, 8'h00);
    idle(16 * WIN + 4);
    chk("R8 fast down to zero", dly_word, 17'h1005A);
    wr(3'd2, 8'hFF);
    idle(64 * WIN + 4);
    chk("R8 fast full range", dly_word, 17'h1FF5A);

    phase = "R11";
    wr(3'd4, 8'h01); wr(3'd2, 8'h00);
    idle(255 * WIN + 4);
    chk("R7 R11 slow full range down", dly_word, 17'h1005A);

    phase = "R10";
    wr(3'd2, 8'h10);
    idle(3 * WIN);
    wr(3'd2, 8'h00);
    idle(4 * WIN + 4);
    chk("R10 redirect back", dly_word, 17'h1005A);

    phase = "R6";
    wr(3'd2, 8'h08); wr(3'd1, 8'h11); wr(3'd3, 8'h00);
    idle(1);
    chk("R6 fine/inv during slew", {dly_word[16], dly_word[7:0]}, {1'b0, 8'h11});

    phase = "R4";
    snap = dly_word;
    cal_word = 17'h1ABCD;
    wr(3'd0, 8'h01);
    wr(3'd1, 8'h77);
    idle(2 * WIN);
    chk("R4 hold while not done", dly_word, snap);
    phase = "R3";
    cal_done = 1'b1;
    idle(2);
    chk("R3 cal word taken", dly_word, 17'h1ABCD);
    wr(3'd2, 8'h44);
    idle(1);
    chk("R3 manual ignored", dly_word, 17'h1ABCD);
    phase = "R4";
    cal_done = 1'b0; cal_word = 17'h00123;
    idle(3);
    chk("R4 hold after done drops", dly_word, 17'h1ABCD);

    phase = "R10";
    wr(3'd2, 8'h08); wr(3'd3, 8'h01);
    wr(3'd0, 8'h00);
    idle(2);
    chk("R10 slew starts from cal coarse", {dly_word[16], dly_word[7:0]}, {1'b1, 8'h77});
    idle(163 * WIN + 4);
    chk("R10 manual target reached", dly_word, 17'h10877);

    phase = "R5";
    wr(3'd4, 8'h00); wr(3'd2, 8'hC0);
    idle(1);
    chk("R5 direct after slew off", dly_word, 17'h1C077);

    idle(4);
    cmp_on = 0;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule